// File: doc/BRIEF.md
# Placeholder Operation Decoder

This block is one decode stage of a RISC-V pipeline. It recognises the instruction words reserved as placeholder operations. These words must execute harmlessly on a core that gives them no further meaning. It accepts one instruction word per handshake, together with a flag that selects between the 32-bit and the 16-bit encoding space. One cycle later it presents a registered result:

- a hit flag;
- the form of the operation;
- the operation number;
- the register specifiers;
- a register-file write request.

The two 32-bit forms are the single-source form (32 operations) and the dual-source form (8 operations). Both complete by writing zero to their destination register. Neither has to read its sources, and neither raises an exception. The 16-bit form occupies eight otherwise reserved code points of the compressed load-upper-immediate instruction with a zero immediate. It never writes a register. The output side has a valid/ready handshake, so a stalled consumer holds the result in place. Words that match none of the patterns leave the stage with the hit flag low and every field at zero.

Top module: `phop_decode`

## Requirements
- R1: With `in_is_c`=0, a word with bit 31=1, bits 29:28=00, bits 25:22=0111, bits 14:12=100 and bits 6:0=1110011 is a hit. It gives kind=1, number={bit30,bit27,bit26,bit21,bit20} (MSB first), rs1=bits 19:15, rd=bits 11:7 and rs2=0.
- R2: With `in_is_c`=0, a word with bit 31=1, bits 29:28=00, bit 25=1, bits 14:12=100 and bits 6:0=1110011 is a hit. It gives kind=2, number={0,0,bit30,bit27,bit26}, rs2=bits 24:20, rs1=bits 19:15 and rd=bits 11:7.
- R3: A kind 1 or kind 2 hit with nonzero rd asserts `out_we`, and `out_wdata` is zero.
- R4: A kind 1 or kind 2 hit with rd=0 keeps `out_we` low.
- R5: With `in_is_c`=1, only bits 15:0 are examined, and bits 31:16 are ignored. A hit requires bits 15:13=011, bit 12=0, bit 11=0, bit 7=1, bits 6:2=00000 and bits 1:0=01. It gives kind=3, number=bits 10:8, rd=2·number+1, rs1=rs2=0 and `out_we` low.
- R6: Any other word gives `out_match`=0, kind=0, number, rd, rs1 and rs2 all zero, and `out_we`=0.
- R7: A word accepted on a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` high after that edge. `in_ready` equals NOT `out_valid` OR `out_ready`.
- R8: While `out_valid` is high and `out_ready` is low, every output holds its value.
- R9: A synchronous active-high `rst` clears `out_valid`, including when a result is stalled.
- R10: `in_is_c` alone selects the encoding space. A 16-bit pattern presented with `in_is_c`=0 is not a hit, and a 32-bit pattern presented with `in_is_c`=1 is not a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word present |
| in_ready | output | 1 | Stage can accept a word |
| in_instr | input | 32 | Instruction word (low half used when compressed) |
| in_is_c | input | 1 | 1 = 16-bit encoding space |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_match | output | 1 | Word is a placeholder operation |
| out_kind | output | 2 | 0 none, 1 single-source, 2 dual-source, 3 compressed |
| out_index | output | 5 | Operation number |
| out_rd | output | 5 | Destination specifier |
| out_rs1 | output | 5 | First source specifier |
| out_rs2 | output | 5 | Second source specifier |
| out_we | output | 1 | Register write request |
| out_wdata | output | XLEN | Write data (always zero) |

## Verification
The bench sweeps all 32 single-source numbers, all 8 dual-source numbers and all 8 compressed numbers. Each uses several register choices, so a swapped or missing index bit shows as a wrong number. Words that miss by a single fixed bit separate a precise match from a loose one:

- an even compressed destination;
- a nonzero immediate;
- a flipped bit 29 or bit 24;
- a wrong funct3 or opcode.

Words presented in the wrong encoding space test the selection, and rd=0 cases test write suppression. Random words and irregular valid/ready patterns, including a reset during a stall, test the handshake against a queue-based model.

// File: rtl/phop_pkg.sv
package phop_pkg;
   localparam int unsigned REG_W = 5;
   localparam int unsigned NUM_W = 5;

   typedef enum logic [1:0] {
      PK_NONE = 2'd0,
      PK_ONE  = 2'd1,
      PK_TWO  = 2'd2,
      PK_CMP  = 2'd3
   } phop_kind_e;

   typedef struct packed {
      logic             hit;
      phop_kind_e       kind;
      logic [NUM_W-1:0] num;
      logic [REG_W-1:0] rd;
      logic [REG_W-1:0] rs1;
      logic [REG_W-1:0] rs2;
      logic             wr;
   } phop_dec_t;
endpackage

// File: rtl/phop_match32.sv
module phop_match32
   import phop_pkg::*;
(
   input  logic [31:0] word,
   output phop_dec_t   res
);
   localparam logic [6:0] SYS_OPC = 7'b1110011;
   localparam logic [2:0] SUBFN   = 3'b100;

   logic base_ok, one_src, two_src;

   assign base_ok = word[31] && (word[29:28] == 2'b00) &&
                    (word[14:12] == SUBFN) && (word[6:0] == SYS_OPC);
   assign one_src = base_ok && !word[25] && (word[24:22] == 3'b111);
   assign two_src = base_ok && word[25];

   always_comb begin
      res = '0;
      if (one_src) begin
         res.hit  = 1'b1;
         res.kind = PK_ONE;
         res.num  = {word[30], word[27:26], word[21:20]};
         res.rs1  = word[19:15];
         res.rd   = word[11:7];
         res.wr   = (word[11:7] != '0);
      end else if (two_src) begin
         res.hit  = 1'b1;
         res.kind = PK_TWO;
         res.num  = {2'b00, word[30], word[27:26]};
         res.rs2  = word[24:20];
         res.rs1  = word[19:15];
         res.rd   = word[11:7];
         res.wr   = (word[11:7] != '0);
      end
   end
endmodule

// File: rtl/phop_match16.sv
module phop_match16
   import phop_pkg::*;
(
   input  logic [15:0] half,
   output phop_dec_t   res
);
   logic hit;

   assign hit = (half[15:13] == 3'b011) && !half[12] && !half[11] &&
                half[7] && (half[6:2] == 5'b00000) && (half[1:0] == 2'b01);

   always_comb begin
      res = '0;
      if (hit) begin
         res.hit  = 1'b1;
         res.kind = PK_CMP;
         res.num  = {2'b00, half[10:8]};
         res.rd   = half[11:7];
         res.wr   = 1'b0;
      end
   end
endmodule

// File: rtl/phop_outreg.sv
module phop_outreg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   if (W == 0) begin : g_bad_w
      $error("phop_outreg: W must be nonzero");
   end

   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         if (in_ready) out_valid <= in_valid;
         if (in_valid && in_ready) out_data <= in_data;
      end
   end

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   // R7
   accept_shows_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/phop_decode.sv
module phop_decode
   import phop_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter bit          ENABLE_C = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   output logic            in_ready,
   input  logic [31:0]     in_instr,
   input  logic            in_is_c,
   output logic            out_valid,
   input  logic            out_ready,
   output logic            out_match,
   output logic [1:0]      out_kind,
   output logic [NUM_W-1:0] out_index,
   output logic [REG_W-1:0] out_rd,
   output logic [REG_W-1:0] out_rs1,
   output logic [REG_W-1:0] out_rs2,
   output logic            out_we,
   output logic [XLEN-1:0] out_wdata
);
   localparam int unsigned DEC_W = $bits(phop_dec_t);

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("phop_decode: XLEN must be 32 or 64");
   end

   phop_dec_t dec32, dec16, dec_sel, dec_q;

   phop_match32 u_m32 (.word(in_instr), .res(dec32));

   if (ENABLE_C) begin : g_cmp
      phop_match16 u_m16 (.half(in_instr[15:0]), .res(dec16));
   end else begin : g_nocmp
      assign dec16 = '0;
   end

   assign dec_sel = in_is_c ? dec16 : dec32;

   phop_outreg #(.W(DEC_W)) u_oreg (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  (dec_sel),
      .out_valid(out_valid),
      .out_ready(out_ready),
      .out_data (dec_q)
   );

   assign out_match = dec_q.hit;
   assign out_kind  = dec_q.kind;
   assign out_index = dec_q.num;
   assign out_rd    = dec_q.rd;
   assign out_rs1   = dec_q.rs1;
   assign out_rs2   = dec_q.rs2;
   assign out_we    = dec_q.wr;
   assign out_wdata = '0;

   // R3
   wr_needs_wide_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_we |-> out_match && (out_kind == 2'd1 || out_kind == 2'd2));

   // R4
   wr_not_x0_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_we |-> out_rd != '0);

   // R5
   cmp_no_wr_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_kind == 2'd3 |-> !out_we && out_rd[0]);

   // R6
   miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_match |-> out_kind == 2'd0 && out_index == '0 &&
      out_rd == '0 && out_rs1 == '0 && out_rs2 == '0 && !out_we);
endmodule

// File: tb/phop_decode_test.sv
module phop_decode_test;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic       hit;
      logic [1:0] kind;
      logic [4:0] num;
      logic [4:0] rd;
      logic [4:0] rs1;
      logic [4:0] rs2;
      logic       we;
   } exp_t;

   typedef struct packed {
      logic [31:0] w;
      logic        c;
      logic        r10;
   } stim_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_instr = '0;
   logic        in_is_c = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic        out_match;
   logic [1:0]  out_kind;
   logic [4:0]  out_index, out_rd, out_rs1, out_rs2;
   logic        out_we;
   logic [31:0] out_wdata;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit done = 1'b0;

   exp_t  expq[$];
   string tagq[$];
   stim_t stims[$];
   bit    model_valid = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   phop_decode uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_instr(in_instr), .in_is_c(in_is_c), .out_valid(out_valid),
      .out_ready(out_ready), .out_match(out_match), .out_kind(out_kind),
      .out_index(out_index), .out_rd(out_rd), .out_rs1(out_rs1),
      .out_rs2(out_rs2), .out_we(out_we), .out_wdata(out_wdata)
   );

   task automatic check(input string tag, input bit ok,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [31:0] w, input logic c);
      exp_t e;
      e = '0;
      if (c) begin
         if (w[15:13] == 3'b011 && w[12] == 1'b0 && w[11] == 1'b0 && w[7] == 1'b1 &&
             w[6:2] == 5'd0 && w[1:0] == 2'b01) begin
            e.hit = 1'b1; e.kind = 2'd3; e.num = {2'b00, w[10:8]};
            e.rd = 5'(2 * int'(w[10:8]) + 1);
         end
      end else if (w[31] == 1'b1 && w[29:28] == 2'b00 && w[14:12] == 3'b100 &&
                   w[6:0] == 7'h73) begin
         if (w[25] == 1'b0 && w[24:22] == 3'b111) begin
            e.hit = 1'b1; e.kind = 2'd1;
            e.num = {w[30], w[27], w[26], w[21], w[20]};
            e.rs1 = w[19:15];
         end else if (w[25] == 1'b1) begin
            e.hit = 1'b1; e.kind = 2'd2;
            e.num = {2'b00, w[30], w[27], w[26]};
            e.rs1 = w[19:15]; e.rs2 = w[24:20];
         end
         if (e.hit) begin
            e.rd = w[11:7];
            e.we = (w[11:7] != 5'd0);
         end
      end
      return e;
   endfunction

   function automatic string tag_of(input exp_t e, input bit r10);
      if (e.kind == 2'd1) return "R1";
      if (e.kind == 2'd2) return "R2";
      if (e.kind == 2'd3) return "R5";
      return r10 ? "R10" : "R6";
   endfunction

   function automatic logic [31:0] enc_one(input logic [4:0] n, input logic [4:0] s1,
                                           input logic [4:0] d);
      return {1'b1, n[4], 2'b00, n[3:2], 4'b0111, n[1:0], s1, 3'b100, d, 7'h73};
   endfunction

   function automatic logic [31:0] enc_two(input logic [2:0] n, input logic [4:0] s2,
                                           input logic [4:0] s1, input logic [4:0] d);
      return {1'b1, n[2], 2'b00, n[1:0], 1'b1, s2, s1, 3'b100, d, 7'h73};
   endfunction

   function automatic logic [31:0] enc_cmp(input logic [2:0] n, input logic [15:0] up);
      return {up, 3'b011, 1'b0, 1'b0, n, 1'b1, 5'b00000, 2'b01};
   endfunction

   task automatic add(input logic [31:0] w, input logic c, input logic r10);
      stim_t s;
      s.w = w; s.c = c; s.r10 = r10;
      stims.push_back(s);
   endtask

   // One clock: check outputs at the falling edge, then drive the next inputs
   task automatic step(input logic v, input logic [31:0] w, input logic c,
                       input logic r10, input logic rdy, output bit accepted);
      exp_t got, e;
      bit exp_ready, popped;
      @(negedge clk);
      check("R7/R8 valid", out_valid == model_valid, 64'(out_valid), 64'(model_valid));
      if (model_valid && expq.size() > 0) begin
         got = {out_match, out_kind, out_index, out_rd, out_rs1, out_rs2, out_we};
         check(tagq[0], got == expq[0], 64'(got), 64'(expq[0]));
         check(expq[0].we ? "R3 write" : (expq[0].hit && expq[0].kind != 2'd3 ? "R4 no-write" : "R6/R5 write"),
               out_we == expq[0].we && out_wdata == 32'd0,
               {31'd0, out_we, out_wdata}, {31'd0, expq[0].we, 32'd0});
      end
      in_valid = v; in_instr = w; in_is_c = c; out_ready = rdy;
      #1;
      exp_ready = !model_valid || rdy;
      check("R7 ready", in_ready == exp_ready, 64'(in_ready), 64'(exp_ready));
      popped = model_valid && rdy;
      if (popped) begin
         void'(expq.pop_front());
         void'(tagq.pop_front());
      end
      accepted = v && exp_ready;
      if (accepted) begin
         e = model(w, c);
         expq.push_back(e);
         tagq.push_back(tag_of(e, r10));
         model_valid = 1'b1;
      end else if (popped) begin
         model_valid = 1'b0;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 20000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      bit acc;
      for (int i = 0; i < 32; i++) add(enc_one(5'(i), 5'(i + 3), 5'(31 - i)), 1'b0, 1'b0);
      for (int i = 0; i < 8; i++) add(enc_two(3'(i), 5'(i + 9), 5'(i * 2), 5'(i + 1)), 1'b0, 1'b0);
      for (int i = 0; i < 8; i++) add(enc_cmp(3'(i), 16'($urandom)), 1'b1, 1'b0);
      // R4 destination x0
      add(enc_one(5'd17, 5'd4, 5'd0), 1'b0, 1'b0);
      add(enc_two(3'd5, 5'd7, 5'd2, 5'd0), 1'b0, 1'b0);
      // R6 near misses
      add(enc_cmp(3'd2, 16'h0) | 32'h1000, 1'b1, 1'b0);
      add(enc_cmp(3'd3, 16'h0) & ~32'h80, 1'b1, 1'b0);
      add(enc_cmp(3'd1, 16'h0) | 32'h800, 1'b1, 1'b0);
      add(enc_cmp(3'd4, 16'h0) | 32'h4, 1'b1, 1'b0);
      add(enc_one(5'd3, 5'd1, 5'd2) | 32'h2000_0000, 1'b0, 1'b0);
      add(enc_one(5'd3, 5'd1, 5'd2) & ~32'h0100_0000, 1'b0, 1'b0);
      add(enc_one(5'd8, 5'd1, 5'd2) & ~32'h0000_4000, 1'b0, 1'b0);
      add(enc_two(3'd6, 5'd1, 5'd2, 5'd3) & ~32'h8000_0000, 1'b0, 1'b0);
      add(enc_two(3'd6, 5'd1, 5'd2, 5'd3) ^ 32'h0000_0040, 1'b0, 1'b0);
      add(32'h0000_0013, 1'b0, 1'b0);
      // R10 wrong encoding space
      add(enc_cmp(3'd5, 16'h0), 1'b0, 1'b1);
      add(enc_one(5'd9, 5'd3, 5'd5), 1'b1, 1'b1);
      add(enc_two(3'd1, 5'd3, 5'd5, 5'd6), 1'b1, 1'b1);
      for (int i = 0; i < 150; i++) add($urandom, 1'($urandom), 1'b0);

      // R9 reset state
      repeat (3) @(negedge clk);
      check("R9 reset valid", out_valid == 1'b0, 64'(out_valid), 64'd0);
      check("R9 reset ready", in_ready == 1'b1, 64'(in_ready), 64'd1);
      rst = 1'b0;

      for (int k = 0; k < stims.size(); ) begin
         logic v, rdy;
         v   = ((cyc % 7) != 2);
         rdy = ((cyc % 5) != 3) && ((cyc % 11) != 4);
         step(v, stims[k].w, stims[k].c, stims[k].r10, rdy, acc);
         if (acc) k++;
      end
      repeat (3) step(1'b0, 32'd0, 1'b0, 1'b0, 1'b1, acc);

      // R8 long stall then R9 reset during the stall
      step(1'b1, enc_one(5'd21, 5'd6, 5'd7), 1'b0, 1'b0, 1'b0, acc);
      repeat (4) step(1'b1, enc_two(3'd3, 5'd1, 5'd1, 5'd1), 1'b0, 1'b0, 1'b0, acc);
      @(negedge clk);
      check("R8 stalled valid", out_valid == 1'b1, 64'(out_valid), 64'd1);
      rst = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);
      check("R9 clear on reset", out_valid == 1'b0, 64'(out_valid), 64'd0);
      rst = 1'b0;
      model_valid = 1'b0;
      expq.delete();
      tagq.delete();
      step(1'b1, enc_cmp(3'd7, 16'hffff), 1'b1, 1'b0, 1'b1, acc);
      repeat (2) step(1'b0, 32'd0, 1'b0, 1'b0, 1'b1, acc);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule